// File: doc/BRIEF.md
# Key-Locked Two-Expiry Watchdog Timer

This block is a memory-mapped watchdog. It has a simple 32-bit register port with read and write strobes, a word address, write data and registered read data. A down-counter reloads from a programmable load register. The first time it reaches zero, it raises an interrupt. If software has not serviced that interrupt by the next time the counter reaches zero, the block sends out a one-cycle system reset request, provided reset is enabled.

Software services the watchdog by writing the interrupt-clear register. That write drops the pending interrupt and restarts the count from the load register. Every register other than the lock register is write-protected until software writes a fixed key to the lock register. Any other value written there protects the registers again.

Word addresses: load 0x000, current count 0x001, control 0x002 (bit 0 runs the counter and the interrupt, bit 1 allows the reset request), interrupt clear 0x003, interrupt status 0x005, lock 0x300. Multiplied by four, these give byte offsets 0x000, 0x004, 0x008, 0x00C, 0x014 and 0xC00.

Top module: `wdog_lock2`

## Requirements
- R1: After reset the lock register reads 1, control reads 0, load reads 0xFFFFFFFF, the count reads 0xFFFFFFFF, status reads 0, and both `irq` and `sys_rst_req` are low.
- R2: Writing 0x1ACCE551 to the lock register makes it read 0. Writing any other value makes it read 1. The lock register accepts writes at all times.
- R3: While the lock register reads 1, writes to load, control and interrupt clear have no effect.
- R4: A read with `rd_en` high places the addressed register on `rdata` one cycle later. `rdata` holds that value until the next read. Unmapped addresses read 0.
- R5: While control bit 0 is set, the count drops by one every cycle. While it is clear, the count is frozen and the interrupt state does not change.
- R6: When the count is 0 and control bit 0 is set, the next cycle reloads the count from the load register and sets the pending interrupt. `irq` and status bit 0 show the pending interrupt.
- R7: An unlocked write to interrupt clear with data bit 0 set clears the pending interrupt and reloads the count from the load register in the next cycle. It takes precedence over a coincident expiry, which then produces no reset request. A write with data bit 0 clear does nothing.
- R8: An expiry that occurs while the interrupt is still pending and control bit 1 is set drives `sys_rst_req` high for exactly the cycle of the reload. `irq` stays high.
- R9: With control bit 1 clear, expiries never assert `sys_rst_req`.
- R10: A write to the load register does not change the running count. The new value is used only at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 10 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Pending first-expiry interrupt |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
Every result appears one clock edge after its cause:
- register writes, the lock state and the count step;
- the interrupt flag and the reset pulse;
- read data.

The bench keeps a behavioural model that it updates at each rising edge from the inputs present at that edge. It compares `irq`, `sys_rst_req` and `rdata` against the model 2 ns after every edge. Inputs change only on falling edges, so nothing is sampled while it is changing. The same-cycle clash between a clear write and an expiry is forced by issuing the clear on the falling edge at which the model's count has just reached zero.

// File: rtl/wdog_lock2.sv
module wdog_lock2 #(
  parameter int          ADDR_W  = 10,
  parameter int          CNT_W   = 32,
  parameter logic [31:0] UNLOCK  = 32'h1ACCE551
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq,
  output logic              sys_rst_req
);
  localparam logic [ADDR_W-1:0] A_LOAD = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'(12'h300);

  logic [CNT_W-1:0] load_q, cnt_q;
  logic [1:0]       ctrl_q;
  logic             locked_q, pend_q;

  wire wr_ok   = wr_en && !locked_q;
  wire clr_hit = wr_ok && addr == A_CLR && wdata[0];
  wire run     = ctrl_q[0];
  wire expire  = run && cnt_q == '0 && !clr_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b1;
      load_q   <= '1;
      ctrl_q   <= 2'b00;
    end else if (wr_en) begin
      if (addr == A_LOCK)      locked_q <= (wdata != UNLOCK);
      else if (!locked_q) begin
        if (addr == A_LOAD)    load_q <= wdata[CNT_W-1:0];
        if (addr == A_CTRL)    ctrl_q <= wdata[1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '1;
      pend_q      <= 1'b0;
      sys_rst_req <= 1'b0;
    end else begin
      sys_rst_req <= expire && pend_q && ctrl_q[1];
      if (clr_hit) begin
        cnt_q  <= load_q;
        pend_q <= 1'b0;
      end else if (expire) begin
        cnt_q  <= load_q;
        pend_q <= 1'b1;
      end else if (run) begin
        cnt_q  <= cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) begin
      case (addr)
        A_LOAD:  rdata <= 32'(load_q);
        A_CNT:   rdata <= 32'(cnt_q);
        A_CTRL:  rdata <= {30'd0, ctrl_q};
        A_STAT:  rdata <= {31'd0, pend_q};
        A_LOCK:  rdata <= {31'd0, locked_q};
        default: rdata <= '0;
      endcase
    end
  end

  assign irq = pend_q;

  AST_LOCKED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && wr_en && addr == A_LOAD) |=> $stable(load_q)); // R3
  AST_FROZEN_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[0] && !clr_hit) |=> ($stable(cnt_q) && $stable(pend_q))); // R5
  AST_IRQ_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(cnt_q) == '0); // R6
  AST_RST_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> irq); // R8
  AST_RST_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> $past(ctrl_q[1])); // R9
endmodule

// File: tb/tb_wdog_lock2.sv
module tb_wdog_lock2;
  localparam logic [31:0] KEY = 32'h1ACCE551;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq, sys_rst_req;
  int checks = 0, fails = 0, rst_seen = 0;

  wdog_lock2 dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .sys_rst_req(sys_rst_req));

  always #4 clk = ~clk;

  // behavioural reference
  longint m_cnt = 32'hFFFFFFFF, m_load = 32'hFFFFFFFF;
  int m_ctrl = 0;
  bit m_lock = 1, m_pend = 0, m_rst = 0;
  logic [31:0] m_rdata = '0;

  always @(posedge clk) begin
    if (rst_n) begin
      longint n_cnt, n_load; int n_ctrl; bit n_lock, n_pend, n_rst, clr;
      n_cnt = m_cnt; n_load = m_load; n_ctrl = m_ctrl; n_lock = m_lock;
      n_pend = m_pend; n_rst = 0;
      if (rd_en)
        case (addr)
          10'h000: m_rdata = m_load[31:0];
          10'h001: m_rdata = m_cnt[31:0];
          10'h002: m_rdata = m_ctrl;
          10'h005: m_rdata = m_pend;
          10'h300: m_rdata = m_lock;
          default: m_rdata = 0;
        endcase
      clr = wr_en && !m_lock && addr == 10'h003 && wdata[0];
      if (clr) begin n_cnt = m_load; n_pend = 0; end
      else if (m_ctrl % 2 == 1) begin
        if (m_cnt == 0) begin
          n_cnt = m_load;
          if (m_pend && m_ctrl >= 2) n_rst = 1;
          n_pend = 1;
        end else n_cnt = m_cnt - 1;
      end
      if (wr_en) begin
        if (addr == 10'h300) n_lock = (wdata != KEY);
        else if (!m_lock) begin
          if (addr == 10'h000) n_load = wdata;
          if (addr == 10'h002) n_ctrl = wdata % 4;
        end
      end
      m_cnt = n_cnt; m_load = n_load; m_ctrl = n_ctrl; m_lock = n_lock;
      m_pend = n_pend; m_rst = n_rst;
      #2;
      chk("R6", irq, m_pend);
      chk("R8", sys_rst_req, m_rst);
      chk("R4", rdata, m_rdata);
      if (sys_rst_req) rst_seen++;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [9:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic main();
    logic [31:0] v, w;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1", {30'd0, irq, sys_rst_req}, 0);
    rd(10'h300, v); chk("R1", v, 1);
    rd(10'h002, v); chk("R1", v, 0);
    rd(10'h000, v); chk("R1", v, 32'hFFFFFFFF);
    rd(10'h001, v); chk("R1", v, 32'hFFFFFFFF);
    rd(10'h005, v); chk("R1", v, 0);
    wr(10'h000, 5); rd(10'h000, v); chk("R3", v, 32'hFFFFFFFF);
    wr(10'h002, 3); rd(10'h002, v); chk("R3", v, 0);
    wr(10'h300, KEY); rd(10'h300, v); chk("R2", v, 0);
    rd(10'h3FF, v); chk("R4", v, 0);
    wr(10'h000, 10); rd(10'h001, v); chk("R10", v, 32'hFFFFFFFF);
    idle(3); rd(10'h001, w); chk("R5", w, v);
    wr(10'h003, 0); rd(10'h001, v); chk("R7", v, 32'hFFFFFFFF);
    wr(10'h003, 1); rd(10'h001, v); chk("R7", v, 10);
    wr(10'h002, 1);
    idle(14); chk("R6", irq, 1);
    wr(10'h000, 4);
    idle(30); chk("R9", rst_seen, 0);
    wr(10'h003, 1); chk("R7", irq, 0);
    wr(10'h002, 3);
    idle(12); chk("R8", rst_seen > 0, 1);
    base = rst_seen;
    while (m_cnt != 0) @(negedge clk);
    wr_en = 1; addr = 10'h003; wdata = 1;
    @(negedge clk); wr_en = 0;
    chk("R7", irq, 0); chk("R7", sys_rst_req, 0);
    chk("R8", rst_seen, base);
    wr(10'h300, 32'h0); rd(10'h300, v); chk("R2", v, 1);
    wr(10'h002, 0); rd(10'h002, v); chk("R3", v, 3);
    wr(10'h003, 1); idle(12); chk("R3", irq, 1);
    wr(10'h300, KEY); wr(10'h002, 0);
    rd(10'h001, v); idle(4); rd(10'h001, w); chk("R5", w, v);
    idle(2);
  endtask

  initial begin
    fork
      main();
      begin repeat (20000) @(posedge clk); fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion"); end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule